// File: doc/BRIEF.md
# SONET Framing Word Aligner

This block sits after a byte-wide deserializer whose byte boundaries fall at an arbitrary bit position in the serial stream. Each clock it takes in one raw byte and keeps a short bit history. It tests all eight bit offsets of that history against the SONET/SDH framing pattern. The pattern is either the two-byte A1,A2 sequence or the four-byte A1,A1,A2,A2 sequence. The offset of the most recent hit is latched, and the block then cuts every later output byte at that offset.

Alignment is pattern-triggered rather than run by a state machine. A match sets the sync flag and loads the offset. The offset then holds until another match or a reset. A one-cycle detect pulse marks the output byte that opens the matched pattern.

Three run-time controls adapt the block to the link. The first bit-reverses each incoming byte so that links sending the least significant bit first are searched in transmission order. The second bit-reverses the whole programmed pattern before the compare. The third bit-reverses each outgoing byte. A build parameter can fix the block to the four-byte pattern, and in that build the size-select input has no effect.

Top module: `sfa_frame_aligner`

## Requirements
- R1: While rst_n is low and in the cycle after its release, in_sync=0, pat_det=0, bit_off=0 and algn_byte=0.
- R2: With len_sel=0, the 16-bit pattern {A1,A2} = 16'hF628 is found at any of the 8 bit offsets. The stream is taken first-bit-in-bit-7. If the pattern starts at stream bit 8*j+k, where byte j is captured at clock edge j, then pat_det is high after edge j+5 and bit_off=k.
- R3: With len_sel=1, only the 32-bit pattern {A1,A1,A2,A2} = 32'hF6F62828 triggers, with the same timing as R2. A lone 16'hF628 gives no pat_det.
- R4: When the LONG_ONLY parameter is 1, len_sel is ignored and only the 32-bit pattern triggers.
- R5: After edge t, algn_byte holds stream bits 8*(t-5)+bit_off through 8*(t-5)+bit_off+7, with the earliest bit in bit 7. In the pat_det cycle algn_byte is the first pattern byte.
- R6: A match sets in_sync, which stays high until reset. bit_off changes only in a pat_det cycle. A new match at another offset moves bit_off.
- R7: With pat_rev=1, the compared pattern is the full bit-reversal of the selected pattern (16'h146F in 16-bit mode), and the unreversed pattern no longer triggers.
- R8: With in_rev=1, each input byte is bit-reversed before it enters the search history.
- R9: With out_rev=1, each output byte is bit-reversed (A1 0xF6 appears as 0x6F).
- R10: pat_det is high for one cycle per pattern occurrence.
- R11: Driving rst_n low at any time clears in_sync and bit_off at once, and they stay clear after release until a new match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_byte | input | 8 | Raw deserialized byte, arbitrary bit boundary |
| len_sel | input | 1 | 0: 16-bit pattern, 1: 32-bit pattern |
| pat_rev | input | 1 | Bit-reverse the programmed pattern before compare |
| in_rev | input | 1 | Bit-reverse each input byte |
| out_rev | input | 1 | Bit-reverse each output byte |
| algn_byte | output | 8 | Realigned byte |
| pat_det | output | 1 | One-cycle pulse on the first byte of a matched pattern |
| in_sync | output | 1 | Set by the first match, held until reset |
| bit_off | output | 3 | Latched bit offset of the last match |

## Verification
The hardest case is a second match at a new bit offset while the block is already in sync. That case alone shows the offset moving while the sync flag stays set. The bench builds bit-level streams in which the pattern is placed at an exact bit position, and it feeds them byte by byte. One stream holds two patterns at different offsets. Other streams hold a lone short pattern in long mode, or a reversed pattern with and without the reverse control. A second instance built for the four-byte pattern only receives the same stream, so the ignored size select is seen at its outputs.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;
  typedef enum logic {
    SIZE_SHORT = 1'b0,
    SIZE_LONG  = 1'b1
  } pat_size_e;
endpackage

// File: rtl/sfa_pattern.sv
`timescale 1ns/1ps
// Builds the compare patterns from the programmed A1/A2 bytes.
module sfa_pattern
  import sfa_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] A1_BYTE   = 8'hF6,
  parameter logic [DATA_W-1:0] A2_BYTE   = 8'h28,
  parameter bit                LONG_ONLY = 1'b0
) (
  input  logic                  len_sel,
  input  logic                  pat_rev,
  output logic [2*DATA_W-1:0]   pat_short,
  output logic [4*DATA_W-1:0]   pat_long,
  output pat_size_e             size
);
  localparam int SHORT_W = 2 * DATA_W;
  localparam int LONG_W  = 4 * DATA_W;

  logic [SHORT_W-1:0] base_s;
  logic [LONG_W-1:0]  base_l;
  logic [SHORT_W-1:0] rev_s;
  logic [LONG_W-1:0]  rev_l;

  assign base_s = {A1_BYTE, A2_BYTE};
  assign base_l = {A1_BYTE, A1_BYTE, A2_BYTE, A2_BYTE};

  for (genvar i = 0; i < SHORT_W; i++) begin : g_rev_s
    assign rev_s[i] = base_s[SHORT_W-1-i];
  end
  for (genvar i = 0; i < LONG_W; i++) begin : g_rev_l
    assign rev_l[i] = base_l[LONG_W-1-i];
  end

  always_comb begin
    pat_short = pat_rev ? rev_s : base_s;
    pat_long  = pat_rev ? rev_l : base_l;
  end

  if (LONG_ONLY) begin : g_fixed_long
    logic unused_sel;
    assign unused_sel = len_sel;
    assign size = SIZE_LONG;
  end else begin : g_sel_size
    assign size = len_sel ? SIZE_LONG : SIZE_SHORT;
  end
endmodule

// File: rtl/sfa_history.sv
`timescale 1ns/1ps
// Sliding bit history of the incoming stream, earliest bit at the top.
module sfa_history #(
  parameter int DATA_W = 8,
  parameter int HIST_W = 5 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              in_rev,
  output logic [HIST_W-2:0] win_src
);
  logic [DATA_W-1:0] din_rev;
  logic [DATA_W-1:0] din_f;
  logic [HIST_W-1:0] sh_q;
  logic [HIST_W-1:0] sh_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_in_rev
    assign din_rev[i] = din[DATA_W-1-i];
  end

  always_comb begin
    din_f = in_rev ? din_rev : din;
    sh_d  = {sh_q[HIST_W-DATA_W-1:0], din_f};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // The newest bit only feeds the shift; compares start one bit higher.
  assign win_src = sh_q[HIST_W-1:1];
endmodule

// File: rtl/sfa_match.sv
`timescale 1ns/1ps
// Compares all bit offsets against the active pattern; lowest offset wins.
module sfa_match
  import sfa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SRC_W  = 5 * DATA_W - 1,
  parameter int OFF_W  = $clog2(DATA_W)
) (
  input  logic [SRC_W-1:0]      win_src,
  input  logic [2*DATA_W-1:0]   pat_short,
  input  logic [4*DATA_W-1:0]   pat_long,
  input  pat_size_e             size,
  output logic                  hit,
  output logic [OFF_W-1:0]      hit_off
);
  localparam int SHORT_W = 2 * DATA_W;
  localparam int LONG_W  = 4 * DATA_W;

  logic [DATA_W-1:0] hit_vec;

  for (genvar k = 0; k < DATA_W; k++) begin : g_off
    logic [LONG_W-1:0] win;
    assign win = win_src[SRC_W-1-k -: LONG_W];
    assign hit_vec[k] = (size == SIZE_LONG) ? (win == pat_long)
                                            : (win[LONG_W-1 -: SHORT_W] == pat_short);
  end

  always_comb begin
    hit_off = '0;
    for (int k = DATA_W - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_off = OFF_W'(k);
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/sfa_frame_aligner.sv
`timescale 1ns/1ps
// Top: SONET framing-pattern word aligner.
module sfa_frame_aligner
  import sfa_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] A1_BYTE   = 8'hF6,
  parameter logic [DATA_W-1:0] A2_BYTE   = 8'h28,
  parameter bit                LONG_ONLY = 1'b0,
  localparam int               OFF_W     = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              len_sel,
  input  logic              pat_rev,
  input  logic              in_rev,
  input  logic              out_rev,
  output logic [DATA_W-1:0] algn_byte,
  output logic              pat_det,
  output logic              in_sync,
  output logic [OFF_W-1:0]  bit_off
);
  localparam int HIST_W = 5 * DATA_W;
  localparam int SRC_W  = HIST_W - 1;

  logic [SRC_W-1:0]      win_src;
  logic [2*DATA_W-1:0]   pat_short;
  logic [4*DATA_W-1:0]   pat_long;
  pat_size_e             size;
  logic                  hit;
  logic [OFF_W-1:0]      hit_off;

  logic [OFF_W-1:0]      off_q, off_d;
  logic                  sync_q, sync_d;
  logic                  det_q, det_d;
  logic [DATA_W-1:0]     out_q, out_d;
  logic [DATA_W-1:0]     byte_sel, byte_rev;
  logic [DATA_W-1:0]     slc [DATA_W];

  sfa_pattern #(
    .DATA_W(DATA_W), .A1_BYTE(A1_BYTE), .A2_BYTE(A2_BYTE), .LONG_ONLY(LONG_ONLY)
  ) u_pattern (
    .len_sel(len_sel), .pat_rev(pat_rev),
    .pat_short(pat_short), .pat_long(pat_long), .size(size)
  );

  sfa_history #(.DATA_W(DATA_W), .HIST_W(HIST_W)) u_history (
    .clk(clk), .rst_n(rst_n), .din(rx_byte), .in_rev(in_rev), .win_src(win_src)
  );

  sfa_match #(.DATA_W(DATA_W), .SRC_W(SRC_W), .OFF_W(OFF_W)) u_match (
    .win_src(win_src), .pat_short(pat_short), .pat_long(pat_long), .size(size),
    .hit(hit), .hit_off(hit_off)
  );

  // Byte slice at each candidate offset.
  for (genvar k = 0; k < DATA_W; k++) begin : g_slice
    assign slc[k] = win_src[SRC_W-1-k -: DATA_W];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_out_rev
    assign byte_rev[i] = byte_sel[DATA_W-1-i];
  end

  // Next-state logic.
  always_comb begin
    off_d    = hit ? hit_off : off_q;
    sync_d   = sync_q | hit;
    det_d    = hit;
    byte_sel = slc[off_d];
    out_d    = out_rev ? byte_rev : byte_sel;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      det_q  <= 1'b0;
      out_q  <= '0;
    end else begin
      sync_q <= sync_d;
      det_q  <= det_d;
      out_q  <= out_d;
    end
  end

  // Offset register, loaded only on a match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   off_q <= '0;
    else if (hit) off_q <= off_d;
  end

  assign algn_byte = out_q;
  assign pat_det   = det_q;
  assign in_sync   = sync_q;
  assign bit_off   = off_q;
endmodule

// File: rtl/sfa_frame_aligner_chk.sv
`timescale 1ns/1ps
module sfa_frame_aligner_chk #(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] A1_BYTE = 8'hF6,
  parameter logic [DATA_W-1:0] A2_BYTE = 8'h28,
  localparam int               OFF_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pat_rev,
  input logic              out_rev,
  input logic [DATA_W-1:0] algn_byte,
  input logic              pat_det,
  input logic              in_sync,
  input logic [OFF_W-1:0]  bit_off
);
  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  // R1: registers cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!in_sync && !pat_det && bit_off == '0));

  // R6: a detect always comes with sync
  p_det_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pat_det |-> in_sync);

  // R6: sync is sticky
  p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |=> in_sync);

  // R6: offset moves only together with a detect
  p_off_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_off) |-> pat_det);

  // R5: the detect byte is the first byte of the compared pattern
  p_first_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pat_det |-> algn_byte == ($past(pat_rev)
                              ? ($past(out_rev) ? A2_BYTE : flip(A2_BYTE))
                              : ($past(out_rev) ? flip(A1_BYTE) : A1_BYTE)));
endmodule

bind sfa_frame_aligner sfa_frame_aligner_chk #(
  .DATA_W(DATA_W), .A1_BYTE(A1_BYTE), .A2_BYTE(A2_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pat_rev(pat_rev), .out_rev(out_rev),
  .algn_byte(algn_byte), .pat_det(pat_det), .in_sync(in_sync), .bit_off(bit_off)
);

// File: tb/sfa_frame_aligner_tb.sv
`timescale 1ns/1ps
module sfa_frame_aligner_tb;
  localparam int NB = 32;

  logic       clk, rst_n;
  logic [7:0] rx_byte;
  logic       len_sel, pat_rev, in_rev, out_rev;
  logic [7:0] algn_byte, lo_byte;
  logic       pat_det, in_sync, lo_det, lo_sync;
  logic [2:0] bit_off, lo_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] sb     [NB];
  logic       det_l  [NB];
  logic       sync_l [NB];
  logic [2:0] off_l  [NB];
  logic [7:0] out_l  [NB];
  logic       lodet_l[NB];
  logic [2:0] looff_l[NB];

  sfa_frame_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .len_sel(len_sel),
    .pat_rev(pat_rev), .in_rev(in_rev), .out_rev(out_rev),
    .algn_byte(algn_byte), .pat_det(pat_det), .in_sync(in_sync), .bit_off(bit_off)
  );

  sfa_frame_aligner #(.LONG_ONLY(1'b1)) u_dut_lo (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .len_sel(len_sel),
    .pat_rev(pat_rev), .in_rev(in_rev), .out_rev(out_rev),
    .algn_byte(lo_byte), .pat_det(lo_det), .in_sync(lo_sync), .bit_off(lo_off)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] get8(input int pos);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = sb[(pos+i)/8][7-((pos+i)%8)];
    return r;
  endfunction

  task automatic clr_stream();
    for (int i = 0; i < NB; i++) sb[i] = 8'h00;
  endtask

  task automatic put_bits(input logic [31:0] v, input int w, input int pos);
    for (int i = 0; i < w; i++) sb[(pos+i)/8][7-((pos+i)%8)] = v[w-1-i];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_byte = in_rev ? rev8(sb[i]) : sb[i];
      @(posedge clk);
      #4;
      det_l[i]   = pat_det;
      sync_l[i]  = in_sync;
      off_l[i]   = bit_off;
      out_l[i]   = algn_byte;
      lodet_l[i] = lo_det;
      looff_l[i] = lo_off;
    end
  endtask

  function automatic int ndet(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += int'(det_l[i]);
    return c;
  endfunction

  function automatic int nlodet(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += int'(lodet_l[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(in_sync == 1'b0, "R1 sync", int'(in_sync), 0);
    chk(pat_det == 1'b0, "R1 det", int'(pat_det), 0);
    chk(bit_off == 3'd0, "R1 off", int'(bit_off), 0);
    chk(algn_byte == 8'h00, "R1 byte", int'(algn_byte), 0);
  endtask

  task automatic t_short_offsets();
    int ks[3] = '{0, 3, 7};
    len_sel = 1'b0;
    foreach (ks[n]) begin
      int k = ks[n];
      clr_stream();
      put_bits(32'h0000F628, 16, 32 + k);
      run(16);
      if (n == 0) chk(sync_l[8] == 1'b0, "R1 no sync before match", int'(sync_l[8]), 0);
      chk(det_l[9] == 1'b1, "R2 det", int'(det_l[9]), 1);
      chk(off_l[9] == 3'(k), "R2 offset", int'(off_l[9]), k);
      chk(ndet(16) == 1, "R10 single pulse", ndet(16), 1);
      chk(out_l[9] == 8'hF6, "R5 first byte", int'(out_l[9]), 'hF6);
      for (int t = 10; t < 16; t++)
        chk(out_l[t] == get8(8*(t-5) + k), "R5 realigned byte", int'(out_l[t]), int'(get8(8*(t-5)+k)));
    end
  endtask

  task automatic t_long();
    len_sel = 1'b1;
    clr_stream();
    put_bits(32'h0000F628, 16, 35);
    run(16);
    chk(ndet(16) == 0, "R3 short ignored in long mode", ndet(16), 0);
    chk(off_l[15] == 3'd7, "R6 offset held", int'(off_l[15]), 7);
    chk(sync_l[15] == 1'b1, "R6 sync held", int'(sync_l[15]), 1);
    clr_stream();
    put_bits(32'hF6F62828, 32, 29);
    run(16);
    chk(det_l[8] == 1'b1, "R3 det", int'(det_l[8]), 1);
    chk(off_l[8] == 3'd5, "R3 offset", int'(off_l[8]), 5);
    chk(out_l[8] == 8'hF6 && out_l[9] == 8'hF6 && out_l[10] == 8'h28,
        "R5 long bytes", int'({out_l[8], out_l[9], out_l[10]}), 'hF6F628);
    chk(lodet_l[8] == 1'b1, "R4 long-only det", int'(lodet_l[8]), 1);
  endtask

  task automatic t_long_only();
    len_sel = 1'b0;
    clr_stream();
    put_bits(32'h0000F628, 16, 34);
    run(16);
    chk(det_l[9] == 1'b1, "R2 det main", int'(det_l[9]), 1);
    chk(nlodet(16) == 0, "R4 size select ignored", nlodet(16), 0);
    clr_stream();
    put_bits(32'hF6F62828, 32, 22);
    run(16);
    chk(det_l[8] == 1'b1 && off_l[8] == 3'd6, "R2 short inside long",
        int'({det_l[8], off_l[8]}), 'hE);
    chk(lodet_l[7] == 1'b1 && looff_l[7] == 3'd6, "R4 long-only det",
        int'({lodet_l[7], looff_l[7]}), 'hE);
  endtask

  task automatic t_pat_rev();
    len_sel = 1'b0;
    pat_rev = 1'b1;
    clr_stream();
    put_bits(32'h0000146F, 16, 36);
    run(16);
    chk(det_l[9] == 1'b1, "R7 reversed pattern det", int'(det_l[9]), 1);
    chk(out_l[9] == 8'h14, "R7 first byte", int'(out_l[9]), 'h14);
    clr_stream();
    put_bits(32'h0000F628, 16, 36);
    run(16);
    chk(ndet(16) == 0, "R7 plain pattern ignored", ndet(16), 0);
    pat_rev = 1'b0;
  endtask

  task automatic t_in_rev();
    len_sel = 1'b0;
    in_rev  = 1'b1;
    clr_stream();
    put_bits(32'h0000F628, 16, 33);
    run(16);
    chk(det_l[9] == 1'b1 && off_l[9] == 3'd1, "R8 input reversal",
        int'({det_l[9], off_l[9]}), 'h9);
    chk(out_l[9] == 8'hF6, "R8 byte", int'(out_l[9]), 'hF6);
    in_rev = 1'b0;
  endtask

  task automatic t_out_rev();
    len_sel = 1'b0;
    out_rev = 1'b1;
    clr_stream();
    put_bits(32'h0000F628, 16, 38);
    run(16);
    chk(out_l[9] == 8'h6F, "R9 reversed first byte", int'(out_l[9]), 'h6F);
    chk(out_l[10] == rev8(get8(46)), "R9 reversed next byte", int'(out_l[10]), int'(rev8(get8(46))));
    out_rev = 1'b0;
  endtask

  task automatic t_relock();
    bit all_sync = 1'b1;
    len_sel = 1'b0;
    clr_stream();
    put_bits(32'h0000F628, 16, 35);
    put_bits(32'h0000F628, 16, 86);
    run(24);
    chk(det_l[9] == 1'b1 && det_l[15] == 1'b1, "R6 two detects",
        int'({det_l[9], det_l[15]}), 3);
    chk(off_l[14] == 3'd3, "R6 first offset held", int'(off_l[14]), 3);
    chk(off_l[15] == 3'd6, "R6 offset moved", int'(off_l[15]), 6);
    for (int t = 9; t < 24; t++) all_sync &= sync_l[t];
    chk(all_sync, "R6 sync stays", int'(all_sync), 1);
    chk(out_l[16] == get8(8*11 + 6), "R5 byte after relock", int'(out_l[16]), int'(get8(94)));
  endtask

  task automatic t_midreset();
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(in_sync == 1'b0 && bit_off == 3'd0, "R11 async clear",
        int'({in_sync, bit_off}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #4;
    chk(in_sync == 1'b0 && pat_det == 1'b0, "R11 clear after release",
        int'({in_sync, pat_det}), 0);
  endtask

  initial begin
    #(64'd20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b1;
    rx_byte = 8'h00;
    len_sel = 1'b0;
    pat_rev = 1'b0;
    in_rev  = 1'b0;
    out_rev = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #4;
    t_reset();
    t_short_offsets();
    t_long();
    t_long_only();
    t_pat_rev();
    t_in_rev();
    t_out_rev();
    t_relock();
    t_midreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule